// File: doc/BRIEF.md
# Cipher Peripheral Status Monitor

This block holds the status and access-policing state of a block-cipher peripheral's register interface. It keeps a result-ready flag that tracks whether valid output is waiting. It also keeps a sticky flag that records that a forbidden register access has occurred, and a 3-bit code for the kind of the latest forbidden access. The cipher datapath is outside the block. It reports through two busy levels, one for data processing and one for subkey generation, and through a one-cycle completion pulse. A transfer-drain pulse stands in for the DMA handshake.

Which event clears the ready flag depends on the operation mode and on a mode bit that selects the clearing event. In manual and auto mode, that bit selects either a read of an output data register or a write of an input data register. In DMA mode, register accesses do not touch the flag, and only the drain pulse clears it. The flags and the access code are packed into one status word. Each flag, gated by its own enable bit, drives a single interrupt line.

Top module: `cipher_status_mon`

## Requirements
- R1: After hardware reset, `status_word` is all zero, both interrupt enables are off and `irq` is 0.
- R2: A `done_pulse` sets the ready flag (bit 0). A `start_cmd` clears it, and a start in the same cycle as a done leaves it cleared.
- R3: A `soft_rst_cmd` clears the ready flag, the forbidden-access flag and the access code. It wins over a done pulse or a forbidden access in the same cycle, and it leaves the interrupt enables unchanged.
- R4: With `op_mode` 0 (manual) or 1 (auto) and `lod_sel`=0, a read (`acc_write`=0) of class 2 (output data) clears the ready flag. No other access clears it. A done pulse in the same cycle keeps the flag set.
- R5: With `op_mode` 0 or 1 and `lod_sel`=1, a write of class 1 (input data) clears the ready flag. No other access, including an output-data read, clears it.
- R6: With `op_mode` 2 (DMA), no register access changes the ready flag, and `dma_drain` clears it. In any other mode `dma_drain` has no effect.
- R7: A forbidden access sets the code as follows: 0 = class-1 write during processing with `op_mode` 2; 1 = class-2 read during processing; 2 = class-3 (mode register) write during processing; 3 = class-2 read during subkey generation; 4 = class-3 write during subkey generation; 5 = class-4 (write-only register) read in any phase. Class 0 is any other register. Every other access is legal.
- R8: When `busy_proc` and `busy_subkey` are both high, an access is classified as if only subkey generation were active.
- R9: The forbidden-access flag (bit 8) stays set until a soft reset. The code holds the latest forbidden access. Legal accesses change neither.
- R10: `status_word` carries the ready flag at bit 0, the forbidden-access flag at bit 8 and the code zero-extended in bits 15:12. All other bits read 0.
- R11: `irq` is (ready AND enable[0]) OR (forbidden flag AND enable[1]). An `ien_set` bit turns its enable on and an `ien_clr` bit turns it off, and clear wins when both arrive in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| acc_valid | input | 1 | One register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_class | input | 3 | Register class: 0 other, 1 input data, 2 output data, 3 mode, 4 write-only |
| start_cmd | input | 1 | Start command pulse |
| soft_rst_cmd | input | 1 | Soft reset command pulse |
| op_mode | input | 2 | 0 manual, 1 auto, 2 DMA |
| lod_sel | input | 1 | Selects the access that clears the ready flag |
| busy_proc | input | 1 | Datapath is processing data |
| busy_subkey | input | 1 | Datapath is generating subkeys |
| done_pulse | input | 1 | Operation completed |
| dma_drain | input | 1 | DMA transfer has taken the result |
| ien_set | input | 2 | Set interrupt enables (bit 0 ready, bit 1 forbidden access) |
| ien_clr | input | 2 | Clear interrupt enables |
| status_word | output | 16 | Packed status |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of mode, clear-select bit, busy pair, register class and direction. For each one it first sets the ready flag and then applies a single access. A design that mixes up the two clearing selections, lets register traffic clear the flag in DMA mode, or lets processing win over subkey generation shows the wrong ready bit or the wrong code in that sweep. Directed cases cover same-cycle collisions: soft reset against done and against a forbidden access, start against done, and done against a clearing read. They also check that the sticky flag survives legal traffic and that clear wins over set on an enable. A wrong priority shows up as a ready flag or sticky flag left set, or as an interrupt that stays enabled.

// File: rtl/csm_pkg.sv
package csm_pkg;

  typedef enum logic [2:0] {
    RC_OTHER = 3'd0,
    RC_IDATA = 3'd1,
    RC_ODATA = 3'd2,
    RC_MODE  = 3'd3,
    RC_WONLY = 3'd4
  } reg_class_e;

  typedef enum logic [1:0] {
    OM_MANUAL = 2'd0,
    OM_AUTO   = 2'd1,
    OM_DMA    = 2'd2,
    OM_RSVD   = 2'd3
  } op_mode_e;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    AT_IDATA_WR_PROC = 3'd0,
    AT_ODATA_RD_PROC = 3'd1,
    AT_MODE_WR_PROC  = 3'd2,
    AT_ODATA_RD_SUBK = 3'd3,
    AT_MODE_WR_SUBK  = 3'd4,
    AT_WONLY_RD      = 3'd5
  } acc_type_e;

  typedef struct packed {
    logic              hit;
    logic [CODE_W-1:0] code;
  } acc_verdict_t;

  // Classify one access against the current engine phase.
  // Subkey generation dominates processing when both are busy.
  function automatic acc_verdict_t judge_access(
    input logic       wr,
    input logic [2:0] cls,
    input logic [1:0] mode,
    input logic       bproc,
    input logic       bsub
  );
    acc_verdict_t v;
    logic in_sub;
    logic in_proc;
    v       = '0;
    in_sub  = bsub;
    in_proc = bproc & ~bsub;
    if (cls == RC_WONLY && !wr) begin
      v = '{hit: 1'b1, code: AT_WONLY_RD};
    end else if (in_sub) begin
      if (cls == RC_ODATA && !wr)     v = '{hit: 1'b1, code: AT_ODATA_RD_SUBK};
      else if (cls == RC_MODE && wr)  v = '{hit: 1'b1, code: AT_MODE_WR_SUBK};
    end else if (in_proc) begin
      if (cls == RC_IDATA && wr && mode == OM_DMA) v = '{hit: 1'b1, code: AT_IDATA_WR_PROC};
      else if (cls == RC_ODATA && !wr)             v = '{hit: 1'b1, code: AT_ODATA_RD_PROC};
      else if (cls == RC_MODE && wr)               v = '{hit: 1'b1, code: AT_MODE_WR_PROC};
    end
    return v;
  endfunction

  // Does this register access retire the ready flag (non-DMA modes only)?
  function automatic logic access_clears_ready(
    input logic       wr,
    input logic [2:0] cls,
    input logic [1:0] mode,
    input logic       lod
  );
    if (mode == OM_DMA) return 1'b0;
    if (lod) return wr && (cls == RC_IDATA);
    return !wr && (cls == RC_ODATA);
  endfunction

endpackage

// File: rtl/csm_ready_flag.sv
module csm_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start,
  input  logic done,
  input  logic acc_clr,
  input  logic dma_mode,
  input  logic dma_drain,
  output logic rdy
);

  logic drain_clr;
  logic rdy_q;

  assign drain_clr = dma_mode & dma_drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdy_q <= 1'b0;
    else if (soft_rst || start)  rdy_q <= 1'b0;
    else if (done)               rdy_q <= 1'b1;
    else if (acc_clr || drain_clr) rdy_q <= 1'b0;
  end

  assign rdy = rdy_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rdy_q);  // R2
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !soft_rst) |=> rdy_q);  // R2
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && rdy_q && !dma_drain && !start && !soft_rst) |=> rdy_q);  // R6

endmodule

// File: rtl/csm_access_log.sv
module csm_access_log
  import csm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_class,
  input  logic [1:0]        op_mode,
  input  logic              busy_proc,
  input  logic              busy_subkey,
  output logic              bad_flag,
  output logic [CODE_W-1:0] bad_code,
  output logic              bad_event
);

  acc_verdict_t verdict;
  logic              flag_q;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    verdict   = judge_access(acc_write, acc_class, op_mode, busy_proc, busy_subkey);
    bad_event = acc_valid & verdict.hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (soft_rst) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (bad_event) begin
      flag_q <= 1'b1;
      code_q <= verdict.code;
    end
  end

  assign bad_flag = flag_q;
  assign bad_code = code_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !soft_rst) |=> flag_q);  // R9
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_event && !soft_rst) |=> $stable(code_q));  // R9
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_event |=> (code_q <= CODE_W'(AT_WONLY_RD)));  // R7
  AST_WONLY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_class == RC_WONLY && !soft_rst) |=> (code_q == AT_WONLY_RD));  // R7
  AST_SUBK_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_class == RC_MODE && busy_subkey && !soft_rst) |=> (code_q == AT_MODE_WR_SUBK));  // R8

endmodule

// File: rtl/csm_irq_gate.sv
module csm_irq_gate #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] en_set,
  input  logic [N_SRC-1:0] en_clr,
  output logic             irq
);

  logic [N_SRC-1:0] en_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q[i] <= 1'b0;
      else if (en_clr[i]) en_q[i] <= 1'b0;
      else if (en_set[i]) en_q[i] <= 1'b1;
    end

    AST_EN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr[i] |=> !en_q[i]);  // R11
  end

  assign irq = |(src & en_q);

endmodule

// File: rtl/cipher_status_mon.sv
module cipher_status_mon
  import csm_pkg::*;
#(
  parameter int unsigned STATUS_W = 16,
  parameter int unsigned RDY_BIT  = 0,
  parameter int unsigned FLAG_BIT = 8,
  parameter int unsigned CODE_LSB = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [2:0]          acc_class,
  input  logic                start_cmd,
  input  logic                soft_rst_cmd,
  input  logic [1:0]          op_mode,
  input  logic                lod_sel,
  input  logic                busy_proc,
  input  logic                busy_subkey,
  input  logic                done_pulse,
  input  logic                dma_drain,
  input  logic [1:0]          ien_set,
  input  logic [1:0]          ien_clr,
  output logic [STATUS_W-1:0] status_word,
  output logic                irq
);

  localparam int unsigned N_IRQ = 2;

  logic              acc_clr;
  logic              dma_mode;
  logic              rdy;
  logic              bad_flag;
  logic [CODE_W-1:0] bad_code;
  logic              bad_event;

  assign dma_mode = (op_mode == OM_DMA);
  assign acc_clr  = acc_valid & access_clears_ready(acc_write, acc_class, op_mode, lod_sel);

  csm_ready_flag u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst_cmd),
    .start     (start_cmd),
    .done      (done_pulse),
    .acc_clr   (acc_clr),
    .dma_mode  (dma_mode),
    .dma_drain (dma_drain),
    .rdy       (rdy)
  );

  csm_access_log u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst_cmd),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_class   (acc_class),
    .op_mode     (op_mode),
    .busy_proc   (busy_proc),
    .busy_subkey (busy_subkey),
    .bad_flag    (bad_flag),
    .bad_code    (bad_code),
    .bad_event   (bad_event)
  );

  csm_irq_gate #(.N_SRC(N_IRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    ({bad_flag, rdy}),
    .en_set (ien_set),
    .en_clr (ien_clr),
    .irq    (irq)
  );

  always_comb begin
    status_word                      = '0;
    status_word[RDY_BIT]             = rdy;
    status_word[FLAG_BIT]            = bad_flag;
    status_word[CODE_LSB +: CODE_W]  = bad_code;
  end

  AST_SRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_cmd |=> (status_word == '0));  // R3
  AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_event && !soft_rst_cmd) |=> status_word[FLAG_BIT]);  // R9
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !dma_mode && !lod_sel && !acc_write && acc_class == RC_ODATA && !done_pulse)
      |=> !status_word[RDY_BIT]);  // R4

endmodule

// File: tb/tb_cipher_status_mon.sv
`timescale 1ns/1ps
module tb_cipher_status_mon;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0;
  logic [2:0]  acc_class = 0;
  logic        start_cmd = 0, soft_rst_cmd = 0;
  logic [1:0]  op_mode = 0;
  logic        lod_sel = 0, busy_proc = 0, busy_subkey = 0;
  logic        done_pulse = 0, dma_drain = 0;
  logic [1:0]  ien_set = 0, ien_clr = 0;
  logic [15:0] status_word;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cipher_status_mon dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_class(acc_class), .start_cmd(start_cmd), .soft_rst_cmd(soft_rst_cmd),
    .op_mode(op_mode), .lod_sel(lod_sel), .busy_proc(busy_proc),
    .busy_subkey(busy_subkey), .done_pulse(done_pulse), .dma_drain(dma_drain),
    .ien_set(ien_set), .ien_clr(ien_clr), .status_word(status_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs are set just after a falling edge; one rising edge later the
  // state is visible at the next falling edge, where pulses drop.
  task automatic step();
    @(negedge clk);
    acc_valid = 0; start_cmd = 0; soft_rst_cmd = 0; done_pulse = 0;
    dma_drain = 0; ien_set = 0; ien_clr = 0;
  endtask

  function automatic logic [15:0] pack(input logic r, input logic f, input logic [2:0] c);
    return {1'b0, c, 3'b000, f, 7'd0, r};
  endfunction

  // -1 means legal access
  function automatic int exp_code(input logic wr, input logic [2:0] cls,
                                  input logic [1:0] m, input logic bp, input logic bs);
    if (cls == 3'd4 && !wr) return 5;
    if (bs) begin
      if (cls == 3'd2 && !wr) return 3;
      if (cls == 3'd3 && wr) return 4;
      return -1;
    end
    if (bp) begin
      if (cls == 3'd1 && wr && m == 2'd2) return 0;
      if (cls == 3'd2 && !wr) return 1;
      if (cls == 3'd3 && wr) return 2;
    end
    return -1;
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    repeat (10000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status_word, 16'h0);
    chk("R1 irq after reset", irq, 0);
    done_pulse = 1; step();
    chk("R1 enables off after reset", irq, 0);

    // R2: start against done
    done_pulse = 1; start_cmd = 1; step();
    chk("R2 start wins over done", status_word[0], 0);
    done_pulse = 1; step();
    chk("R2 done sets ready", status_word[0], 1);
    start_cmd = 1; step();
    chk("R2 start clears ready", status_word[0], 0);

    // R3: soft reset collisions and enables kept
    ien_set = 2'b11; step();
    done_pulse = 1; soft_rst_cmd = 1; step();
    chk("R3 soft reset beats done", status_word, 16'h0);
    acc_valid = 1; acc_write = 0; acc_class = 3'd4; soft_rst_cmd = 1; step();
    chk("R3 soft reset beats forbidden access", status_word, 16'h0);
    done_pulse = 1; soft_rst_cmd = 0; step();
    soft_rst_cmd = 1; step();
    done_pulse = 1; step();
    chk("R3 enables survive soft reset", irq, 1);

    // R4: done beats a clearing read
    op_mode = 0; lod_sel = 0;
    acc_valid = 1; acc_write = 0; acc_class = 3'd2; done_pulse = 1; step();
    chk("R4 done wins over output read", status_word[0], 1);

    // R6: drain only in DMA mode
    op_mode = 2'd2; dma_drain = 1; step();
    chk("R6 drain clears in DMA", status_word[0], 0);
    op_mode = 2'd1; done_pulse = 1; step();
    dma_drain = 1; step();
    chk("R6 drain ignored outside DMA", status_word[0], 1);

    // R9: sticky flag and latest code
    soft_rst_cmd = 1; step();
    acc_valid = 1; acc_write = 0; acc_class = 3'd4; step();
    acc_valid = 1; acc_write = 1; acc_class = 3'd0; step();
    acc_valid = 1; acc_write = 1; acc_class = 3'd3; step();
    chk("R9 legal access keeps flag and code", status_word, pack(0, 1, 3'd5));
    busy_proc = 1;
    acc_valid = 1; acc_write = 0; acc_class = 3'd2; step();
    busy_proc = 0;
    chk("R9 latest code replaces older", status_word, pack(0, 1, 3'd1));

    // R11: enable gating
    ien_clr = 2'b10; step();
    chk("R11 flag masked", irq, 0);
    ien_set = 2'b10; ien_clr = 2'b10; step();
    chk("R11 clear beats set", irq, 0);
    ien_set = 2'b10; step();
    chk("R11 flag enabled", irq, 1);
    soft_rst_cmd = 1; ien_clr = 2'b10; step();
    done_pulse = 1; step();
    chk("R11 ready source with its enable", irq, 1);
    ien_clr = 2'b01; step();
    chk("R11 ready masked", irq, 0);

    // Sweep: every mode, clear-select, busy pair, class, direction
    ien_set = 2'b11; step();
    for (int m = 0; m < 3; m++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 5; c++)
            for (int w = 0; w < 2; w++) begin
              logic exp_r;
              int   ec;
              op_mode = m[1:0]; lod_sel = l[0];
              busy_proc = b[0]; busy_subkey = b[1];
              soft_rst_cmd = 1; step();
              done_pulse = 1; step();
              acc_valid = 1; acc_write = w[0]; acc_class = c[2:0]; step();
              if (m == 2) exp_r = 1'b1;
              else if (l == 0) exp_r = !(w == 0 && c == 2);
              else exp_r = !(w == 1 && c == 1);
              ec = exp_code(w[0], c[2:0], m[1:0], b[0], b[1]);
              if (m == 2)      chk("R6 sweep ready", status_word[0], exp_r);
              else if (l == 0) chk("R4 sweep ready", status_word[0], exp_r);
              else             chk("R5 sweep ready", status_word[0], exp_r);
              if (b == 3) chk("R8 sweep code", status_word[15:8],
                              (ec < 0) ? 8'h00 : {1'b0, 3'(ec), 4'h1});
              else chk("R7 sweep code", status_word[15:8],
                       (ec < 0) ? 8'h00 : {1'b0, 3'(ec), 4'h1});
              chk("R10 status layout", status_word,
                  pack(exp_r, ec >= 0, (ec < 0) ? 3'd0 : 3'(ec)));
              chk("R11 sweep irq", irq, exp_r | (ec >= 0));
            end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule